// File: doc/BRIEF.md
# Four-Channel DMA Arbiter with Favoured-Channel Interleave

This block decides which of four DMA channels is served next. Each channel raises a request line. A one-cycle decision strobe marks each arbitration point. On that strobe the block samples the requests and its configuration, picks a winner, and registers a one-hot grant with a valid flag. The grant holds until the next strobe.

Software may mark one channel as favoured with an enable bit and a 2-bit channel index. While this is enabled, the favoured channel gets one slot after every grant to any other channel. The other channels take turns in round-robin order, so under full load the favoured channel receives half of the grants. While it is disabled, all four channels take turns in plain round-robin order. The configuration is sampled only at a strobe. It can be changed while channels are busy, without any handshake.

All pins are plain control and status signals. There is no streaming interface and no back-pressure: a grant is simply replaced at the next strobe.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `grant` is zero or one-hot, with bit i meaning channel i. It and `grant_vld` are registered: they change only on the clock edge where `decide` is high, and hold their values at every other edge.
- R2: When a decision finds no request, `grant` becomes all-zero and `grant_vld` goes low.
- R3: With `prio_en` low, the channels are served in plain round-robin order, starting at the channel after the one last granted. From reset with all four requesting, the order is 0, 1, 2, 3, 0.
- R4: With `prio_en` high and all channels requesting, a grant to a non-favoured channel is always followed by a grant to the favoured channel. The first decision after reset or after enabling goes to a non-favoured channel. With `prio_sel`=2 and the pointer at 0, the order is 0, 2, 1, 2, 3, 2.
- R5: If the favoured channel is not requesting at its turn, that slot goes to the next requesting non-favoured channel in round-robin order.
- R6: If the favoured channel is the only one requesting, it wins every decision.
- R7: `prio_en` and `prio_sel` are sampled only at a decision. A change between strobes leaves the current grant unchanged and takes effect at the next strobe. `prio_sel` is the binary index of the favoured channel.
- R8: When `prio_sel` moves, the channel that was favoured rejoins the round-robin rotation and the newly favoured channel leaves it.
- R9: A valid grant always names a channel that was requesting at that decision.
- R10: After reset, `grant` is zero, `grant_vld` is low, the round-robin pointer is at channel 0, and the interleave phase is on a non-favoured slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request line per channel |
| prio_en | input | 1 | Enables favoured-channel interleave |
| prio_sel | input | 2 | Index of the favoured channel |
| decide | input | 1 | Arbitration strobe, one decision per high cycle |
| grant | output | 4 | Registered one-hot grant |
| grant_vld | output | 1 | High when `grant` names a channel |

## Verification
The bench looks for a pointer that moves on a favoured grant. Such a design would skip or repeat a non-favoured channel in the interleaved sequence. It also looks for a phase bit that flips when the favoured channel is idle, which would hand the next slot to the wrong channel after a favoured no-show. It checks that a new `prio_sel` puts the old favoured channel back into the rotation; a design that got this wrong would never grant channel 2 once it had been favoured. Finally, it changes the requests and configuration between strobes to catch a grant that reacts to them combinationally.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Which kind of slot the next enabled-priority decision offers first.
  typedef enum logic {
    SLOT_OTHER = 1'b0,
    SLOT_FAV   = 1'b1
  } slot_e;
endpackage

// File: rtl/dma_arb_rr_pick.sv
// Rotating-precedence picker: first set bit of mask at or after ptr.
module dma_arb_rr_pick #(
  parameter int N_CH  = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  mask,
  input  logic [IDX_W-1:0] ptr,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N_CH; i++) begin
      int c;
      c = (int'(ptr) + i) % N_CH;
      if (!any && mask[c]) begin
        any = 1'b1;
        idx = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/dma_arb_decide.sv
// Combinational decision: winner, pointer update and next interleave phase.
module dma_arb_decide
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  req,
  input  logic             prio_en,
  input  logic [IDX_W-1:0] prio_sel,
  input  logic [IDX_W-1:0] ptr,
  input  slot_e            phase,
  output logic             win_any,
  output logic [IDX_W-1:0] win_idx,
  output logic             ptr_upd,
  output slot_e            phase_nxt
);
  logic [N_CH-1:0]  fav_oh;
  logic [N_CH-1:0]  oth_mask;
  logic             fav_req;
  logic             all_any, oth_any;
  logic [IDX_W-1:0] all_idx, oth_idx;

  assign fav_oh   = N_CH'(1) << prio_sel;
  assign oth_mask = req & ~fav_oh;
  assign fav_req  = |(req & fav_oh);

  // One picker over every channel, one over the non-favoured ones.
  dma_arb_rr_pick #(.N_CH(N_CH)) u_pick_all (
    .mask(req), .ptr(ptr), .any(all_any), .idx(all_idx)
  );
  dma_arb_rr_pick #(.N_CH(N_CH)) u_pick_oth (
    .mask(oth_mask), .ptr(ptr), .any(oth_any), .idx(oth_idx)
  );

  always_comb begin
    win_any   = 1'b0;
    win_idx   = '0;
    ptr_upd   = 1'b0;
    phase_nxt = phase;
    if (!prio_en) begin
      win_any   = all_any;
      win_idx   = all_idx;
      ptr_upd   = all_any;
      phase_nxt = SLOT_OTHER;
    end else if (phase == SLOT_FAV && fav_req) begin
      win_any   = 1'b1;
      win_idx   = prio_sel;
      phase_nxt = SLOT_OTHER;
    end else if (oth_any) begin
      win_any   = 1'b1;
      win_idx   = oth_idx;
      ptr_upd   = 1'b1;
      phase_nxt = SLOT_FAV;
    end else if (fav_req) begin
      win_any   = 1'b1;
      win_idx   = prio_sel;
      phase_nxt = SLOT_OTHER;
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  req,
  input  logic             prio_en,
  input  logic [IDX_W-1:0] prio_sel,
  input  logic             decide,
  output logic [N_CH-1:0]  grant,
  output logic             grant_vld
);
  logic [IDX_W-1:0] ptr_q;
  slot_e            phase_q;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic             ptr_upd;
  slot_e            phase_nxt;
  logic [IDX_W-1:0] ptr_next;

  dma_arb_decide #(.N_CH(N_CH)) u_decide (
    .req(req), .prio_en(prio_en), .prio_sel(prio_sel),
    .ptr(ptr_q), .phase(phase_q),
    .win_any(win_any), .win_idx(win_idx),
    .ptr_upd(ptr_upd), .phase_nxt(phase_nxt)
  );

  assign ptr_next = IDX_W'((int'(win_idx) + 1) % N_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_vld <= 1'b0;
      ptr_q     <= '0;
      phase_q   <= SLOT_OTHER;
    end else if (decide) begin
      grant     <= win_any ? (N_CH'(1) << win_idx) : '0;
      grant_vld <= win_any;
      if (ptr_upd) ptr_q <= ptr_next;
      phase_q   <= phase_nxt;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> ($stable(grant) && $stable(grant_vld))); // R1
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req == '0) |=> (!grant_vld && grant == '0)); // R2
  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req != '0) |=> (grant_vld && (grant & $past(req)) != '0)); // R9
  AST_FAV_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && prio_en && req == (N_CH'(1) << prio_sel))
      |=> grant == $past(N_CH'(1) << prio_sel)); // R6
  AST_FAV_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && prio_en && phase_q == SLOT_FAV && req[prio_sel])
      |=> grant == $past(N_CH'(1) << prio_sel)); // R4
endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       prio_en = 1'b0;
  logic [1:0] prio_sel = '0;
  logic       decide = 1'b0;
  logic [3:0] grant;
  logic       grant_vld;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio_en(prio_en),
    .prio_sel(prio_sel), .decide(decide), .grant(grant), .grant_vld(grant_vld)
  );

  // {req, prio_en, prio_sel, expected grant, requirement number}
  localparam int NV = 24;
  localparam logic [14:0] VEC [NV] = '{
    {4'hF, 1'b0, 2'd0, 4'h1, 4'd3},  // R3 rotation from reset
    {4'hF, 1'b0, 2'd0, 4'h2, 4'd3},
    {4'hF, 1'b0, 2'd0, 4'h4, 4'd3},
    {4'hF, 1'b0, 2'd0, 4'h8, 4'd3},
    {4'hA, 1'b0, 2'd0, 4'h2, 4'd3},  // sparse requests
    {4'hA, 1'b0, 2'd0, 4'h8, 4'd3},
    {4'hF, 1'b1, 2'd2, 4'h1, 4'd4},  // R4 interleave, favoured ch2
    {4'hF, 1'b1, 2'd2, 4'h4, 4'd4},
    {4'hF, 1'b1, 2'd2, 4'h2, 4'd4},
    {4'hF, 1'b1, 2'd2, 4'h4, 4'd4},
    {4'hF, 1'b1, 2'd2, 4'h8, 4'd4},
    {4'hF, 1'b1, 2'd2, 4'h4, 4'd4},
    {4'hB, 1'b1, 2'd2, 4'h1, 4'd5},  // R5 favoured absent
    {4'hB, 1'b1, 2'd2, 4'h2, 4'd5},
    {4'hF, 1'b1, 2'd2, 4'h4, 4'd5},
    {4'h4, 1'b1, 2'd2, 4'h4, 4'd6},  // R6 favoured alone
    {4'h4, 1'b1, 2'd2, 4'h4, 4'd6},
    {4'h0, 1'b1, 2'd2, 4'h0, 4'd2},  // R2 nothing requested
    {4'hF, 1'b1, 2'd0, 4'h4, 4'd8},  // R8 ch2 rejoins, ch0 favoured
    {4'hF, 1'b1, 2'd0, 4'h1, 4'd8},
    {4'hF, 1'b1, 2'd0, 4'h8, 4'd8},
    {4'hF, 1'b1, 2'd0, 4'h1, 4'd8},
    {4'hF, 1'b1, 2'd0, 4'h2, 4'd8},
    {4'hF, 1'b0, 2'd0, 4'h4, 4'd7}   // R7 disable applies at this strobe
  };

  task automatic check(input logic [3:0] exp, input int rq);
    n_run++;
    if (grant !== exp || grant_vld !== (exp != 4'h0)) begin
      n_fail++;
      $display("FAIL R%0d grant=%h vld=%b expected grant=%h vld=%b",
               rq, grant, grant_vld, exp, exp != 4'h0);
    end
  endtask

  task automatic strobe(input logic [3:0] r, input logic en, input logic [1:0] s);
    @(negedge clk);
    req = r; prio_en = en; prio_sel = s; decide = 1'b1;
    @(negedge clk);
    decide = 1'b0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired grant=%h expected completion", grant);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(4'h0, 10);  // R10 reset outputs
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][14:11], VEC[i][10], VEC[i][9:8]);
      check(VEC[i][7:4], int'(VEC[i][3:0]));
    end

    // R1 / R7: inputs move between strobes, grant must hold (last grant 4'h4)
    req = 4'h1; prio_en = 1'b1; prio_sel = 2'd1;
    repeat (3) @(negedge clk);
    check(4'h4, 1);
    req = 4'h0;
    @(negedge clk);
    check(4'h4, 7);

    // R7: the config set between strobes is used now: pointer at 3, phase other
    strobe(4'hF, 1'b1, 2'd1);
    check(4'h8, 7);
    strobe(4'hF, 1'b1, 2'd1);
    check(4'h2, 7);

    // R9: a single non-favoured requester
    strobe(4'h8, 1'b1, 2'd1);
    check(4'h8, 9);

    // R10: reset mid-run restores pointer to channel 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(4'h0, 10);
    rst_n = 1'b1;
    strobe(4'hF, 1'b0, 2'd0);
    check(4'h1, 10);
    // R10: phase starts on non-favoured slot after reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    strobe(4'hF, 1'b1, 2'd0);
    check(4'h2, 10);
    strobe(4'hF, 1'b1, 2'd0);
    check(4'h1, 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule